// File: doc/BRIEF.md
# Hot-Swap Start-Up Sequencer

This block runs one hot-swap channel from a turn-on request to the power-good state. Analog comparators outside the block turn the feedback level, current-limit activity and gate enhancement into digital flags. The block takes those flags, a microsecond tick and a timer mode select. It drives the gate enable and the control levels for the current-limit circuitry, and it decides what happens when the start-up interval ends.

During start-up the gate is enabled, foldback is active and the low current-limit level is selected. The start-up interval comes from one of two sources: an internal count of 100 ms, built from a configurable number of ticks per millisecond, or an external threshold flag from a timing capacitor. When the interval ends, the block samples the current-limit flag. If the channel is still limiting, it raises an overcurrent fault pulse and turns the gate off. If it is not limiting, it strobes the breaker arm, selects the high current-limit level and turns foldback off. Power good is then qualified by the feedback and enhancement flags. Dropping the turn-on request returns the block to idle at any time.

Top module: `hsw_startup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets to idle. After that edge `gate_en`, `foldback_en`, `ilim_high`, `brk_arm_stb`, `oc_fault_pulse` and `pg_ok` are 0 and `pg_status_n` is 1.
- R2: From idle, a clock edge with `on_req` high enters start-up. During start-up `gate_en` is 1, `foldback_en` is 1 (foldback active) and `ilim_high` is 0 (low current-limit level).
- R3: With `use_int_timer` = 1, the interval ends at the edge that counts the (STARTUP_MS × TICKS_PER_MS)-th edge seen with `tick_us` high since start-up began. Edges with `tick_us` low are not counted. The decision is taken at the next edge.
- R4: With `use_int_timer` = 0, the interval ends when `ext_timer_hit` is 1 during start-up. The decision is taken at that same edge, and the internal count has no effect.
- R5: If `ilim_active` is 1 at the decision edge, the block enters the fault state. `oc_fault_pulse` is 1 for exactly one cycle and `gate_en`, `foldback_en` and `ilim_high` are 0. The fault state lasts until `on_req` goes low.
- R6: If `ilim_active` is 0 at the decision edge, the block enters the running state. `brk_arm_stb` is 1 for exactly one cycle, `ilim_high` becomes 1 and `foldback_en` becomes 0, with `gate_en` still 1.
- R7: `pg_ok` is a register. It is 1 after an edge only if, before that edge, the block was running, `on_req` was 1, `fb_above` was 1 and `gate_enh` was 1.
- R8: `pg_status_n` is always the inverse of `pg_ok`.
- R9: A clock edge with `on_req` low sends the block to idle from any state, which clears `gate_en`, `ilim_high`, `foldback_en` and `pg_ok`. A later request starts a full new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | Microsecond tick, one cycle wide |
| on_req | input | 1 | Turn-on request level; low turns the channel off |
| use_int_timer | input | 1 | 1: internal 100 ms count, 0: external threshold flag |
| ext_timer_hit | input | 1 | External timing capacitor crossed its threshold |
| ilim_active | input | 1 | Current-limit loop is active |
| fb_above | input | 1 | Feedback comparator is above its threshold |
| gate_enh | input | 1 | Gate-to-source enhancement flag |
| gate_en | output | 1 | Gate drive enable |
| foldback_en | output | 1 | Current-limit foldback active |
| ilim_high | output | 1 | Current-limit level select: 0 low, 1 high |
| brk_arm_stb | output | 1 | One-cycle strobe that arms the circuit breaker |
| oc_fault_pulse | output | 1 | One-cycle overcurrent fault pulse |
| pg_ok | output | 1 | Power good, active high |
| pg_status_n | output | 1 | Power-good status, 0 when power is good |

## Verification
The gate, foldback and limit-level outputs change at the edge that samples a request or a decision. The strobe and the fault pulse rise at the decision edge and last one cycle. Power good lags its qualifying inputs by one edge. In internal mode the decision falls one edge after the last counted tick, and in external mode it falls at the edge that samples the flag. The bench keeps a behavioural model that is advanced at every rising edge from the same sampled inputs. It compares all outputs against the model at the falling edge, so each check lands in the cycle where the result is due. Inputs change only after that comparison.

// File: rtl/hsw_pkg.sv
// Shared types for the hot-swap start-up sequencer.
// Assumes: one channel per sequencer instance.
package hsw_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_RUN   = 2'd2,
        SEQ_FAULT = 2'd3
    } seq_state_e;
endpackage

// File: rtl/hsw_startup_timer.sv
// Start-up interval timer: counts STARTUP_MS milliseconds of ticks in
// internal mode, or passes the external threshold flag through.
// Assumes: run_i is high only during start-up; tick_i is one cycle wide.
module hsw_startup_timer #(
    parameter int TICKS_PER_MS = 1000,
    parameter int STARTUP_MS   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic use_int_i,
    input  logic ext_hit_i,
    output logic expired_o
);
    localparam int US_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam int MS_W = (STARTUP_MS > 1) ? $clog2(STARTUP_MS) : 1;
    localparam logic [US_W-1:0] US_LAST = US_W'(TICKS_PER_MS - 1);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(STARTUP_MS - 1);

    logic [US_W-1:0] us_q;
    logic [MS_W-1:0] ms_q;
    logic            done_q;

    // Count ticks into milliseconds, then hold the done flag until start-up ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            us_q   <= '0;
            ms_q   <= '0;
            done_q <= 1'b0;
        end else if (tick_i && !done_q) begin
            if (us_q == US_LAST) begin
                us_q <= '0;
                if (ms_q == MS_LAST) done_q <= 1'b1;
                else                 ms_q   <= ms_q + 1'b1;
            end else begin
                us_q <= us_q + 1'b1;
            end
        end
    end

    // Select the interval source.
    always_comb expired_o = use_int_i ? done_q : ext_hit_i;

    AST_MS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q <= MS_LAST); // R3
    AST_US_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        us_q <= US_LAST); // R3
    AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (us_q == '0 && ms_q == '0 && !done_q)); // R9
endmodule

// File: rtl/hsw_seq_fsm.sv
// Sequencer state machine: enters start-up on request, decides between
// fault and run at interval expiry, and returns to idle when the request drops.
// Assumes: expired_i is only meaningful while in start-up.
module hsw_seq_fsm
    import hsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_req_i,
    input  logic       expired_i,
    input  logic       ilim_active_i,
    output seq_state_e state_o,
    output logic       arm_stb_o,
    output logic       oc_pulse_o
);
    seq_state_e state_q, state_d;
    logic       arm_d, oc_d;

    // Next-state and decision logic.
    always_comb begin
        state_d = state_q;
        arm_d   = 1'b0;
        oc_d    = 1'b0;
        if (!on_req_i) begin
            state_d = SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE:  state_d = SEQ_START;
                SEQ_START: if (expired_i) begin
                    if (ilim_active_i) begin
                        state_d = SEQ_FAULT;
                        oc_d    = 1'b1;
                    end else begin
                        state_d = SEQ_RUN;
                        arm_d   = 1'b1;
                    end
                end
                SEQ_RUN:   state_d = SEQ_RUN;
                SEQ_FAULT: state_d = SEQ_FAULT;
                default:   state_d = SEQ_IDLE;
            endcase
        end
    end

    // State and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            arm_stb_o  <= 1'b0;
            oc_pulse_o <= 1'b0;
        end else begin
            state_q    <= state_d;
            arm_stb_o  <= arm_d;
            oc_pulse_o <= oc_d;
        end
    end

    always_comb state_o = state_q;

    AST_ARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        arm_stb_o |=> !arm_stb_o); // R6
    AST_OC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        oc_pulse_o |=> !oc_pulse_o); // R5
    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_FAULT && on_req_i) |=> state_q == SEQ_FAULT); // R5
    AST_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !on_req_i |=> state_q == SEQ_IDLE); // R9
endmodule

// File: rtl/hsw_pg_qual.sv
// Power-good qualifier: registers the combination of running state,
// request, feedback and enhancement flags.
// Assumes: run_i is high only after a clean start-up decision.
module hsw_pg_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic on_req_i,
    input  logic fb_above_i,
    input  logic gate_enh_i,
    output logic pg_o,
    output logic pg_n_o
);
    // Register the qualified power-good condition.
    always_ff @(posedge clk) begin
        if (!rst_n) pg_o <= 1'b0;
        else        pg_o <= run_i && on_req_i && fb_above_i && gate_enh_i;
    end

    // Status view, active low.
    always_comb pg_n_o = !pg_o;

    AST_PG_NEEDS_FB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_o) |-> $past(fb_above_i && gate_enh_i)); // R7
    AST_PG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pg_o); // R7
endmodule

// File: rtl/hsw_startup_seq.sv
// Hot-swap start-up sequencer top: ties the interval timer, the state
// machine and the power-good qualifier together and decodes the outputs.
// Assumes: comparator flags are already synchronised to clk.
module hsw_startup_seq
    import hsw_pkg::*;
#(
    parameter int TICKS_PER_MS = 1000,
    parameter int STARTUP_MS   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic on_req,
    input  logic use_int_timer,
    input  logic ext_timer_hit,
    input  logic ilim_active,
    input  logic fb_above,
    input  logic gate_enh,
    output logic gate_en,
    output logic foldback_en,
    output logic ilim_high,
    output logic brk_arm_stb,
    output logic oc_fault_pulse,
    output logic pg_ok,
    output logic pg_status_n
);
    seq_state_e state;
    logic       expired;
    logic       in_start, in_run;

    // Decode the state into phase flags.
    always_comb begin
        in_start = (state == SEQ_START);
        in_run   = (state == SEQ_RUN);
    end

    hsw_startup_timer #(
        .TICKS_PER_MS(TICKS_PER_MS),
        .STARTUP_MS  (STARTUP_MS)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (in_start),
        .tick_i   (tick_us),
        .use_int_i(use_int_timer),
        .ext_hit_i(ext_timer_hit),
        .expired_o(expired)
    );

    hsw_seq_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .on_req_i     (on_req),
        .expired_i    (expired),
        .ilim_active_i(ilim_active),
        .state_o      (state),
        .arm_stb_o    (brk_arm_stb),
        .oc_pulse_o   (oc_fault_pulse)
    );

    hsw_pg_qual i_pg (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (in_run),
        .on_req_i  (on_req),
        .fb_above_i(fb_above),
        .gate_enh_i(gate_enh),
        .pg_o      (pg_ok),
        .pg_n_o    (pg_status_n)
    );

    // Drive the channel controls from the phase flags.
    always_comb begin
        gate_en     = in_start || in_run;
        foldback_en = in_start;
        ilim_high   = in_run;
    end

    AST_OC_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oc_fault_pulse |-> (!gate_en && !ilim_high)); // R5
    AST_ARM_RAISES_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        brk_arm_stb |-> (ilim_high && !foldback_en && gate_en)); // R6
    AST_OFF_CLEARS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !on_req |=> (!gate_en && !pg_ok && !ilim_high)); // R9
    AST_PG_STATUS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        pg_ok != pg_status_n); // R8
endmodule

// File: tb/test_hsw_startup_seq.sv
module test_hsw_startup_seq;
    localparam int TPM = 4;
    localparam int SMS = 5;
    localparam int NT  = TPM * SMS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_us = 0, on_req = 0, use_int_timer = 1, ext_timer_hit = 0;
    logic ilim_active = 0, fb_above = 0, gate_enh = 0;
    logic gate_en, foldback_en, ilim_high, brk_arm_stb, oc_fault_pulse, pg_ok, pg_status_n;

    int n_chk = 0, n_fail = 0, tick_div = 1, tick_ph = 0;
    bit finished = 0;

    // Model state: phase 0 idle, 1 start-up, 2 running, 3 fault.
    int m_phase = 0, m_ticks = 0;
    bit m_exp = 0, m_pg = 0, m_arm = 0, m_oc = 0;

    always #2 clk = ~clk;

    hsw_startup_seq #(.TICKS_PER_MS(TPM), .STARTUP_MS(SMS)) i_hsw_startup_seq (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .on_req(on_req),
        .use_int_timer(use_int_timer), .ext_timer_hit(ext_timer_hit),
        .ilim_active(ilim_active), .fb_above(fb_above), .gate_enh(gate_enh),
        .gate_en(gate_en), .foldback_en(foldback_en), .ilim_high(ilim_high),
        .brk_arm_stb(brk_arm_stb), .oc_fault_pulse(oc_fault_pulse),
        .pg_ok(pg_ok), .pg_status_n(pg_status_n));

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        int nph; bit nexp, npg, narm, noc, hit; int ntk;
        if (!rst_n) begin
            m_phase = 0; m_ticks = 0; m_exp = 0; m_pg = 0; m_arm = 0; m_oc = 0;
        end else begin
            npg = (m_phase == 2) && on_req && fb_above && gate_enh;
            hit = use_int_timer ? m_exp : ext_timer_hit;
            nph = m_phase; narm = 0; noc = 0;
            if (!on_req) nph = 0;
            else if (m_phase == 0) nph = 1;
            else if (m_phase == 1 && hit) begin
                if (ilim_active) begin nph = 3; noc = 1; end
                else begin nph = 2; narm = 1; end
            end
            ntk = m_ticks; nexp = m_exp;
            if (m_phase != 1) begin ntk = 0; nexp = 0; end
            else if (tick_us && !m_exp) begin
                ntk = m_ticks + 1;
                if (ntk == NT) nexp = 1;
            end
            m_phase = nph; m_ticks = ntk; m_exp = nexp; m_pg = npg; m_arm = narm; m_oc = noc;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    // Compare every output with the model, away from the rising edge.
    task automatic compare();
        chk(m_phase == 3 ? "R5" : "R2", "gate_en", gate_en, m_phase == 1 || m_phase == 2);
        chk(m_phase == 1 ? "R2" : "R6", "foldback_en", foldback_en, m_phase == 1);
        chk(m_phase == 2 ? "R6" : "R9", "ilim_high", ilim_high, m_phase == 2);
        chk(use_int_timer ? "R3" : "R4", "brk_arm_stb", brk_arm_stb, m_arm);
        chk("R5", "oc_fault_pulse", oc_fault_pulse, m_oc);
        chk("R7", "pg_ok", pg_ok, m_pg);
        chk("R8", "pg_status_n", pg_status_n, !m_pg);
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            tick_ph = (tick_ph + 1) % tick_div;
            tick_us = (tick_ph == 0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1", "gate_en reset", gate_en, 0);
        chk("R1", "pg_status_n reset", pg_status_n, 1);
        chk("R1", "ilim_high reset", ilim_high, 0);
        rst_n = 1;
        cyc(3);
        // R2 R3 R6 R7: internal timer, tick every cycle, clean start.
        fb_above = 1; gate_enh = 1; on_req = 1;
        cyc(NT + 8);
        chk("R6", "running after internal expiry", ilim_high, 1);
        chk("R7", "power good in run", pg_ok, 1);
        // R7: feedback drop clears power good one edge later.
        fb_above = 0; cyc(3);
        chk("R7", "pg low without feedback", pg_ok, 0);
        fb_above = 1; gate_enh = 0; cyc(3);
        chk("R7", "pg low without enhancement", pg_ok, 0);
        gate_enh = 1; cyc(2);
        // R9: turn off from running.
        on_req = 0; cyc(3);
        chk("R9", "gate off after request drop", gate_en, 0);
        // R3 R5: internal timer with limit active at expiry, slow tick.
        tick_div = 3; ilim_active = 1; on_req = 1;
        cyc(3 * NT + 10);
        chk("R5", "fault holds gate off", gate_en, 0);
        ilim_active = 0; cyc(5);
        chk("R5", "fault persists while requested", gate_en, 0);
        on_req = 0; cyc(3);
        // R9: abort mid start-up, restart needs a full interval.
        tick_div = 1; on_req = 1; cyc(NT / 2);
        on_req = 0; cyc(2);
        on_req = 1; cyc(NT - 2);
        chk("R9", "still in start-up after restart", foldback_en, 1);
        cyc(8);
        on_req = 0; cyc(3);
        // R4: external mode, flag decides; internal count ignored.
        use_int_timer = 0; on_req = 1; cyc(NT + 5);
        chk("R4", "no expiry without external flag", foldback_en, 1);
        ext_timer_hit = 1; cyc(1); ext_timer_hit = 0; cyc(4);
        chk("R4", "run after external flag", ilim_high, 1);
        on_req = 0; cyc(3);
        // R4 R5: external flag with limit active.
        on_req = 1; cyc(6);
        ilim_active = 1; ext_timer_hit = 1; cyc(1);
        ext_timer_hit = 0; ilim_active = 0; cyc(4);
        chk("R5", "external fault gate off", gate_en, 0);
        on_req = 0; cyc(4);
        finish_run();
    end
endmodule